// File: doc/BRIEF.md
# Enable-Latched Single-Bit Static RAM

This block is a clocked model of a 1024-word by 1-bit static memory whose access cycle is framed by an active-low chip enable instead of by a free-running address clock. A system clock samples the enable `ce_n` and the active-low write strobe `we_n`. The address is captured into an internal register only when the enable is first seen low. Later address activity is ignored until the enable has gone high and fallen again. A flag `dout_en` takes the place of a three-state output buffer.

The storage is a 32 x 32 matrix. The upper five bits of the captured address pick a row, and the lower five pick a column. A read cycle enables the output one sample before it presents data. A write window is open while enable and strobe are both low. The window closes at whichever of the two rises first, and the data bit seen at that closing sample is stored.

A control state machine sequences every cycle. Its states are:
- IDLE: enable high, output off.
- OPEN: output on, data not yet valid.
- SHOW: output on, data valid.
- WRITE: window open, output off.
- HOLD: strobe released while enable is still low, output off.

The transitions are:
- IDLE→OPEN on an enable fall with the strobe high.
- IDLE→WRITE on an enable fall with the strobe low.
- OPEN→SHOW after one sample.
- OPEN/SHOW/HOLD→WRITE when the strobe is seen low.
- WRITE→HOLD when the strobe rises.
- Any state→IDLE when the enable rises.

Top module: `enlatch_sram1`

## Requirements
- R1: While reset is held and after its release, `dout_en` is 0 and `dout` is 0 until an enable fall is sampled.
- R2: While `ce_n` is sampled high, `dout_en` is 0 and no location is written, whatever `we_n`, `addr` and `din` do.
- R3: The address is captured at the first sample with `ce_n` low after a sample with `ce_n` high. Address changes later in that cycle affect neither the location read nor the location written.
- R4: Address bits [9:5] select one of 32 rows and bits [4:0] select one of 32 columns, so all 1024 addresses are distinct cells.
- R5: In a read cycle (`we_n` high), the first sample after the enable fall shows `dout_en`=1 with `dout`=0. From the next sample on, `dout` carries the stored bit until `ce_n` rises.
- R6: A write window opens at the first sample with `ce_n` and `we_n` both low. `dout_en` is 0 from that sample on, and it is never raised when both fall together.
- R7: A write closes at the first sample in which `ce_n` or `we_n` is high. The `din` value of that closing sample is stored, and earlier values are discarded.
- R8: With `we_n` held low across several enable cycles, each enable rise stores `din` at the address captured at that cycle's enable fall.
- R9: After `we_n` rises while `ce_n` stays low, `dout_en` stays 0 and `din` changes are not stored until a new window opens or the enable rises.
- R10: `dout` is 0 whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| ce_n | input | 1 | Active-low chip enable; its fall starts a cycle |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 10 | Word address, captured at enable fall |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 when output is off |
| dout_en | output | 1 | High when the output would be driven |

## Verification
The assertions assume that the inputs are stable across each clock edge and that `ce_n` is high when reset is released. Under these assumptions the sampled history alone decides every edge. The bench changes inputs only at the falling clock edge and holds the enable high through reset. Write data is checked only at addresses the bench has written itself, because the array starts with undefined contents.

// File: rtl/sram1_pkg.sv
`timescale 1ns/1ps
package sram1_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OPEN  = 3'd1,
        ST_SHOW  = 3'd2,
        ST_WRITE = 3'd3,
        ST_HOLD  = 3'd4
    } cyc_state_t;
endpackage

// File: rtl/sram1_edge_sampler.sv
`timescale 1ns/1ps
// Registers the enable and reports its fall and rise against the live value.
module sram1_edge_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    output logic e_fall,
    output logic e_rise
);
    logic ce_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) ce_prev <= 1'b1;
        else        ce_prev <= ce_n;
    end

    assign e_fall = ce_prev & ~ce_n;
    assign e_rise = ~ce_prev & ce_n;
endmodule

// File: rtl/sram1_ctrl_fsm.sv
`timescale 1ns/1ps
module sram1_ctrl_fsm
    import sram1_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic e_fall,
    input  logic e_rise,
    input  logic we_n,
    output logic latch_en,
    output logic rd_en,
    output logic wr_en,
    output logic show_data,
    output logic dout_en
);
    cyc_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (e_fall) nxt = we_n ? ST_OPEN : ST_WRITE;
            ST_OPEN:  if (e_rise) nxt = ST_IDLE;
                      else if (!we_n) nxt = ST_WRITE;
                      else nxt = ST_SHOW;
            ST_SHOW:  if (e_rise) nxt = ST_IDLE;
                      else if (!we_n) nxt = ST_WRITE;
            ST_WRITE: if (e_rise) nxt = ST_IDLE;
                      else if (we_n) nxt = ST_HOLD;
            ST_HOLD:  if (e_rise) nxt = ST_IDLE;
                      else if (!we_n) nxt = ST_WRITE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        latch_en  = (state == ST_IDLE) && e_fall;
        rd_en     = (state == ST_OPEN);
        wr_en     = (state == ST_WRITE) && (e_rise || we_n);
        show_data = (state == ST_SHOW);
        dout_en   = (state == ST_OPEN) || (state == ST_SHOW);
    end
endmodule

// File: rtl/sram1_bit_matrix.sv
`timescale 1ns/1ps
// Row/column bit array; one generated row word per row, registered read.
module sram1_bit_matrix #(
    parameter int ROW_W = 5,
    parameter int COL_W = 5
) (
    input  logic             clk,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             rd_en,
    output logic             rd_bit
);
    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;

    logic [COLS-1:0] row_word [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] cells;
        always_ff @(posedge clk) begin
            if (wr_en && (row == ROW_W'(r))) cells[col] <= wr_bit;
        end
        assign row_word[r] = cells;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_bit <= row_word[row][col];
    end
endmodule

// File: rtl/enlatch_sram1.sv
`timescale 1ns/1ps
module enlatch_sram1 #(
    parameter int ROW_W = 5,
    parameter int COL_W = 5,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_en
);
    logic              e_fall, e_rise;
    logic              latch_en, rd_en, wr_en, show_data;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_bit;

    sram1_edge_sampler u_edge (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n),
        .e_fall(e_fall), .e_rise(e_rise)
    );

    sram1_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .e_fall(e_fall), .e_rise(e_rise),
        .we_n(we_n), .latch_en(latch_en), .rd_en(rd_en), .wr_en(wr_en),
        .show_data(show_data), .dout_en(dout_en)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        addr_q <= '0;
        else if (latch_en) addr_q <= addr;
    end

    sram1_bit_matrix #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mat (
        .clk(clk),
        .row(addr_q[ADDR_W-1:COL_W]),
        .col(addr_q[COL_W-1:0]),
        .wr_en(wr_en), .wr_bit(din),
        .rd_en(rd_en), .rd_bit(rd_bit)
    );

    assign dout = show_data & rd_bit;
endmodule

// File: rtl/sram1_checker.sv
`timescale 1ns/1ps
module sram1_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              dout,
    input logic              dout_en,
    input logic              wr_en,
    input logic              e_fall,
    input logic [ADDR_W-1:0] addr_q
);
    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> !dout);

    assert_enable_high_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_en);

    assert_enable_high_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && $past(ce_n)) |-> !wr_en);

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !e_fall |=> $stable(addr_q));

    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dout_en) && !ce_n && we_n) |=> dout_en);

    assert_strobe_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && !ce_n && !we_n) |=> !dout_en);

    assert_commit_on_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ce_n || we_n));
endmodule

bind enlatch_sram1 sram1_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .dout(dout), .dout_en(dout_en), .wr_en(wr_en),
    .e_fall(e_fall), .addr_q(addr_q)
);

// File: tb/enlatch_sram1_tb.sv
`timescale 1ns/1ps
module enlatch_sram1_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       we_n = 1'b1;
    logic [9:0] addr = '0;
    logic       din = 1'b0;
    logic       dout, dout_en;

    int checks = 0;
    int fails  = 0;
    logic exp_mem [1024];

    always #4 clk = ~clk;

    enlatch_sram1 u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic write_e(logic [9:0] a, logic d);
        ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        cyc();
        ce_n = 1'b1; we_n = 1'b1;
        cyc();
        exp_mem[a] = d;
    endtask

    task automatic read_at(logic [9:0] a, output logic b, output logic en1);
        ce_n = 1'b0; we_n = 1'b1; addr = a;
        cyc();
        en1 = dout_en;
        cyc();
        b = dout;
        ce_n = 1'b1;
        cyc();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        check("R1", "dout_en in reset", dout_en, 1'b0);
        rst_n = 1'b1;
        cyc();
        check("R1", "dout_en after reset", dout_en, 1'b0);
        check("R1", "dout after reset", dout, 1'b0);
    endtask

    task automatic t_fill(bit inv);
        int bad = 0;
        logic b, e;
        for (int a = 0; a < 1024; a++) write_e(10'(a), (^10'(a)) ^ inv);
        for (int a = 0; a < 1024; a++) begin
            read_at(10'(a), b, e);
            if (b !== exp_mem[a]) bad++;
        end
        check("R4", inv ? "inverse pattern mismatches" : "parity pattern mismatches",
              bad == 0, 1'b1);
    endtask

    task automatic t_read_timing();
        write_e(10'd100, 1'b1);
        ce_n = 1'b0; we_n = 1'b1; addr = 10'd100;
        cyc();
        check("R5", "enable first sample", dout_en, 1'b1);
        check("R5", "data not yet valid", dout, 1'b0);
        cyc();
        check("R5", "data valid second sample", dout, 1'b1);
        cyc();
        check("R5", "data held", dout, 1'b1);
        ce_n = 1'b1;
        cyc();
        check("R2", "enable high turns output off", dout_en, 1'b0);
        check("R10", "dout zero when off", dout, 1'b0);
    endtask

    task automatic t_enable_high();
        logic b, e;
        bit seen = 0;
        write_e(10'd7, 1'b0);
        ce_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            we_n = i[0]; din = 1'b1; addr = 10'd7;
            cyc();
            if (dout_en) seen = 1;
        end
        we_n = 1'b1;
        cyc();
        check("R2", "no output while enable high", seen, 1'b0);
        read_at(10'd7, b, e);
        check("R2", "cell untouched while enable high", b, 1'b0);
    endtask

    task automatic t_addr_hold();
        logic b, e;
        write_e(10'd40, 1'b1);
        write_e(10'd41, 1'b0);
        ce_n = 1'b0; we_n = 1'b1; addr = 10'd40;
        cyc();
        addr = 10'd41;
        cyc();
        check("R3", "read uses captured address", dout, 1'b1);
        ce_n = 1'b1;
        cyc();
        ce_n = 1'b0; we_n = 1'b0; addr = 10'd900; din = 1'b1;
        cyc();
        addr = 10'd41;
        ce_n = 1'b1; we_n = 1'b1;
        cyc();
        exp_mem[900] = 1'b1;
        read_at(10'd41, b, e);
        check("R3", "later address not written", b, 1'b0);
        read_at(10'd900, b, e);
        check("R3", "captured address written", b, 1'b1);
    endtask

    task automatic t_strobe_close();
        logic b, e;
        write_e(10'd300, 1'b0);
        ce_n = 1'b0; we_n = 1'b1; addr = 10'd300;
        cyc();
        check("R6", "output on before strobe", dout_en, 1'b1);
        we_n = 1'b0; din = 1'b0;
        cyc();
        check("R6", "output off once strobe low", dout_en, 1'b0);
        din = 1'b1; cyc();
        din = 1'b0; cyc();
        din = 1'b1;
        we_n = 1'b1;
        cyc();
        check("R9", "output off after strobe rise", dout_en, 1'b0);
        din = 1'b0;
        cyc();
        check("R9", "still off in hold", dout_en, 1'b0);
        ce_n = 1'b1;
        cyc();
        read_at(10'd300, b, e);
        check("R7", "value at strobe rise stored", b, 1'b1);
        check("R9", "data after strobe rise ignored", b, 1'b1);
    endtask

    task automatic t_enable_close();
        logic b, e;
        write_e(10'd513, 1'b1);
        ce_n = 1'b0; we_n = 1'b0; addr = 10'd513; din = 1'b1;
        cyc();
        check("R6", "output never on when both fall", dout_en, 1'b0);
        din = 1'b1; cyc();
        din = 1'b0;
        ce_n = 1'b1;
        cyc();
        we_n = 1'b1; din = 1'b1;
        cyc();
        read_at(10'd513, b, e);
        check("R7", "value at enable rise stored", b, 1'b0);
    endtask

    task automatic t_strobe_held();
        logic b, e;
        logic [9:0] al [4] = '{10'd3, 10'd35, 10'd1000, 10'd512};
        logic       dl [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
        int bad = 0;
        for (int i = 0; i < 4; i++) write_e(al[i], ~dl[i]);
        we_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ce_n = 1'b0; addr = al[i]; din = ~dl[i];
            cyc();
            din = dl[i];
            ce_n = 1'b1;
            cyc();
        end
        we_n = 1'b1;
        cyc();
        for (int i = 0; i < 4; i++) begin
            read_at(al[i], b, e);
            if (b !== dl[i]) bad++;
        end
        check("R8", "held strobe writes per enable cycle", bad == 0, 1'b1);
    endtask

    initial begin
        cyc();
        t_reset();
        t_fill(1'b0);
        t_fill(1'b1);
        t_read_timing();
        t_enable_high();
        t_addr_hold();
        t_strobe_close();
        t_enable_close();
        t_strobe_held();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule